// File: doc/BRIEF.md
# Cache Occupancy Monitor

This block keeps a running measure of how many cache lines belong to one filtered stream of traffic. The cache reports each allocation and eviction as an event carrying a partition identifier, a monitoring group and a line count. When the monitor is enabled and the event passes the optional partition and group filters, allocations add their line count to a 31-bit occupancy value and evictions subtract it, stopping at zero.

Software reaches the monitor through a small register port: a control word, a filter register, the live value register, a read-only capture register and a write-only trigger address. A capture copies the live value and its not-ready flag into the capture register. It can be started by one of six external capture inputs or by a write to the trigger address, and it can optionally clear the live value afterwards. An overflow of the value can wrap or freeze it, set a sticky status bit, drive a level interrupt, take a private capture, and pulse one of six linkage lines that feed the capture inputs of other monitors. A control bit can also send a matching capture event down the overflow path instead of the plain capture path.

Top module: `occupancy_monitor`

## Requirements
- R1: Register addresses are 0 control, 1 filter, 2 value, 3 capture (read-only), 4 capture trigger (write-only, reads zero). The control word holds enable at bit 31, capture select at 30:28, reset-after-capture at 27, overflow status at 26, interrupt enable at 25, freeze at 24, capture-on-overflow at 23, capture-as-overflow at 18, group match at 17, partition match at 16 and linkage select at 10:8. Bits 7:0 always read 0x43, bits 22:19 and 15:11 read zero, and writes to them have no effect. After reset the control word reads 0x00000043 and the value and capture registers read zero.
- R2: While enable is 0, usage events leave the value unchanged.
- R3: A counted allocation adds its line count to the value; a counted eviction subtracts it and stops at zero. The value register reads {not-ready, value[30:0]}; a value write loads bits 30:0 and sets not-ready, and the next counted event clears it.
- R4: The filter register holds the partition identifier in bits 15:0 and the group in bits 23:16. With partition match set, only events whose partition equals the filter are counted; with group match set, only events whose group equals the filter are counted; a clear match bit accepts any value.
- R5: Capture select 0 starts no capture, 1 to 6 select external capture input bits 0 to 5, and 7 selects a write to the trigger address; any other source has no effect.
- R6: A plain capture copies {not-ready, value} into the capture register; with reset-after-capture set the live value then becomes zero.
- R7: An allocation that carries the value past 31 bits is an overflow: the value wraps modulo 2^31 and the status bit is set. Status stays set until a control write puts 0 in it or the value register is written.
- R8: With freeze set, an overflowing allocation leaves the value unchanged and later events have no effect until the value register is written.
- R9: With capture-on-overflow set, an overflow also performs a capture (with reset-after-capture applied) of the post-overflow value.
- R10: A linkage select of 1 to 6 makes an overflow raise link output bit 0 to 5 for exactly the following cycle; select 0 or 7 drives nothing.
- R11: With capture-as-overflow set, a selected capture event sets status and applies freeze, capture-on-overflow and reset-after-capture instead of a plain capture; without capture-on-overflow it leaves the capture register unchanged.
- R12: The interrupt output is high exactly while both status and interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| ev_valid | input | 1 | Usage event present |
| ev_alloc | input | 1 | 1 allocation, 0 eviction |
| ev_part | input | PART_W | Event partition identifier |
| ev_grp | input | GRP_W | Event monitoring group |
| ev_lines | input | LINE_W | Event line count |
| ext_capt | input | 6 | External capture inputs 1 to 6 |
| link_evt | output | 6 | Linkage capture pulses 1 to 6 |
| ovf_irq | output | 1 | Overflow interrupt level |

## Verification
Counting is driven with allocation-only runs, an eviction larger than the value and a mix after a value write, which separates plain addition, the zero floor and the not-ready flag. Filtered runs offer events that differ from the filter only in partition, only in group, and in neither, under each match setting, so a filter that compares the wrong field or ignores a match bit shows up. Capture is tried with the selected source, a non-selected source and the disabled code, and overflows are produced by allocations straddling the 31-bit limit under wrap, freeze, capture-with-reset and each linkage code, so each control bit's effect is seen on its own.

// File: rtl/occ_mon_pkg.sv
package occ_mon_pkg;

    localparam int VAL_W     = 31;
    localparam int N_CAPT    = 6;
    localparam logic [7:0] TYPE_CODE = 8'h43;

    localparam int A_CTL  = 0;
    localparam int A_FLT  = 1;
    localparam int A_VAL  = 2;
    localparam int A_CAPT = 3;
    localparam int A_TRIG = 4;

    typedef struct packed {
        logic       en;
        logic [2:0] capt_sel;
        logic       capt_rst;
        logic       status;
        logic       irq_en;
        logic       frz;
        logic       capt_ovf;
        logic       cap_as_ovf;
        logic       match_grp;
        logic       match_part;
        logic [2:0] link_sel;
    } ctl_t;

    function automatic logic [31:0] ctl_pack(ctl_t c);
        logic [31:0] w;
        w        = '0;
        w[31]    = c.en;
        w[30:28] = c.capt_sel;
        w[27]    = c.capt_rst;
        w[26]    = c.status;
        w[25]    = c.irq_en;
        w[24]    = c.frz;
        w[23]    = c.capt_ovf;
        w[18]    = c.cap_as_ovf;
        w[17]    = c.match_grp;
        w[16]    = c.match_part;
        w[10:8]  = c.link_sel;
        w[7:0]   = TYPE_CODE;
        return w;
    endfunction

    function automatic ctl_t ctl_unpack(logic [31:0] w);
        ctl_t c;
        c.en         = w[31];
        c.capt_sel   = w[30:28];
        c.capt_rst   = w[27];
        c.status     = w[26];
        c.irq_en     = w[25];
        c.frz        = w[24];
        c.capt_ovf   = w[23];
        c.cap_as_ovf = w[18];
        c.match_grp  = w[17];
        c.match_part = w[16];
        c.link_sel   = w[10:8];
        return c;
    endfunction

endpackage

// File: rtl/occ_filter.sv
module occ_filter #(
    parameter int PART_W = 16,
    parameter int GRP_W  = 8
) (
    input  logic              match_part,
    input  logic              match_grp,
    input  logic [PART_W-1:0] ev_part,
    input  logic [GRP_W-1:0]  ev_grp,
    input  logic [PART_W-1:0] flt_part,
    input  logic [GRP_W-1:0]  flt_grp,
    output logic              hit
);
    logic part_ok;
    logic grp_ok;

    assign part_ok = !match_part || (ev_part == flt_part);
    assign grp_ok  = !match_grp  || (ev_grp  == flt_grp);
    assign hit     = part_ok && grp_ok;
endmodule

// File: rtl/occ_capt_sel.sv
module occ_capt_sel #(
    parameter int N_SRC = 6
) (
    input  logic [2:0]       sel,
    input  logic [N_SRC-1:0] ext_capt,
    input  logic             sw_trig,
    output logic             hit
);
    localparam logic [2:0] SW_CODE = 3'd7;

    logic [N_SRC-1:0] ext_hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign ext_hit[i] = ext_capt[i] && (sel == 3'(i + 1));
    end

    assign hit = (|ext_hit) || (sw_trig && (sel == SW_CODE));
endmodule

// File: rtl/occ_link_dec.sv
module occ_link_dec #(
    parameter int N_LINK = 6
) (
    input  logic [2:0]        code,
    input  logic              fire,
    output logic [N_LINK-1:0] link
);
    for (genvar i = 0; i < N_LINK; i++) begin : g_link
        assign link[i] = fire && (code == 3'(i + 1));
    end
endmodule

// File: rtl/occupancy_monitor.sv
module occupancy_monitor
    import occ_mon_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int PART_W = 16,
    parameter int GRP_W  = 8,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_valid,
    input  logic              ev_alloc,
    input  logic [PART_W-1:0] ev_part,
    input  logic [GRP_W-1:0]  ev_grp,
    input  logic [LINE_W-1:0] ev_lines,
    input  logic [N_CAPT-1:0] ext_capt,
    output logic [N_CAPT-1:0] link_evt,
    output logic              ovf_irq
);
    localparam int SUM_W = VAL_W + 1;
    localparam int GRP_LSB = 16;

    typedef struct packed {
        ctl_t              ctl;
        logic [PART_W-1:0] flt_part;
        logic [GRP_W-1:0]  flt_grp;
        logic [VAL_W-1:0]  value;
        logic              nrdy;
        logic [VAL_W-1:0]  capt_val;
        logic              capt_nrdy;
        logic              frozen;
        logic [N_CAPT-1:0] link;
    } state_t;

    state_t st_d, st_q;

    logic wr_ctl, wr_flt, wr_val, sw_trig;
    logic flt_hit, capt_hit;
    logic hw_ovf, ovf_path, do_capt;
    logic [N_CAPT-1:0] link_nx;
    logic [SUM_W-1:0]  sum;
    logic [VAL_W-1:0]  lines_ext;
    logic [VAL_W-1:0]  val_mid;
    logic              nrdy_mid;

    assign wr_ctl  = bus_wr && (bus_addr == ADDR_W'(A_CTL));
    assign wr_flt  = bus_wr && (bus_addr == ADDR_W'(A_FLT));
    assign wr_val  = bus_wr && (bus_addr == ADDR_W'(A_VAL));
    assign sw_trig = bus_wr && (bus_addr == ADDR_W'(A_TRIG));

    occ_filter #(.PART_W(PART_W), .GRP_W(GRP_W)) u_filter (
        .match_part (st_q.ctl.match_part),
        .match_grp  (st_q.ctl.match_grp),
        .ev_part    (ev_part),
        .ev_grp     (ev_grp),
        .flt_part   (st_q.flt_part),
        .flt_grp    (st_q.flt_grp),
        .hit        (flt_hit)
    );

    occ_capt_sel #(.N_SRC(N_CAPT)) u_capt_sel (
        .sel      (st_q.ctl.capt_sel),
        .ext_capt (ext_capt),
        .sw_trig  (sw_trig),
        .hit      (capt_hit)
    );

    occ_link_dec #(.N_LINK(N_CAPT)) u_link_dec (
        .code (st_q.ctl.link_sel),
        .fire (hw_ovf),
        .link (link_nx)
    );

    assign lines_ext = VAL_W'(ev_lines);

    // Usage update: counting, wrap or freeze on overflow.
    always_comb begin
        val_mid  = st_q.value;
        nrdy_mid = st_q.nrdy;
        hw_ovf   = 1'b0;
        sum      = '0;
        if (st_q.ctl.en && ev_valid && flt_hit && !st_q.frozen && !wr_val) begin
            nrdy_mid = 1'b0;
            if (ev_alloc) begin
                sum    = {1'b0, st_q.value} + SUM_W'(ev_lines);
                hw_ovf = sum[VAL_W];
                if (!(hw_ovf && st_q.ctl.frz)) begin
                    val_mid = sum[VAL_W-1:0];
                end
            end else if (st_q.value > lines_ext) begin
                val_mid = st_q.value - lines_ext;
            end else begin
                val_mid = '0;
            end
        end
    end

    assign ovf_path = hw_ovf || (capt_hit && st_q.ctl.cap_as_ovf);
    assign do_capt  = (capt_hit && !st_q.ctl.cap_as_ovf) || (ovf_path && st_q.ctl.capt_ovf);

    // Next-state: capture, then software writes, then overflow status.
    always_comb begin
        st_d       = st_q;
        st_d.value = val_mid;
        st_d.nrdy  = nrdy_mid;
        st_d.link  = link_nx;
        if (do_capt) begin
            st_d.capt_val  = val_mid;
            st_d.capt_nrdy = nrdy_mid;
            if (st_q.ctl.capt_rst) begin
                st_d.value = '0;
            end
        end
        if (ovf_path && st_q.ctl.frz) begin
            st_d.frozen = 1'b1;
        end
        if (wr_ctl) begin
            st_d.ctl = ctl_unpack(bus_wdata);
        end
        if (wr_flt) begin
            st_d.flt_part = bus_wdata[PART_W-1:0];
            st_d.flt_grp  = bus_wdata[GRP_LSB +: GRP_W];
        end
        if (wr_val) begin
            st_d.value  = bus_wdata[VAL_W-1:0];
            st_d.nrdy   = 1'b1;
            st_d.frozen = 1'b0;
            if (st_q.ctl.status) begin
                st_d.ctl.status = 1'b0;
            end
        end
        if (ovf_path) begin
            st_d.ctl.status = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTL)) begin
            bus_rdata = ctl_pack(st_q.ctl);
        end else if (bus_addr == ADDR_W'(A_FLT)) begin
            bus_rdata = (32'(st_q.flt_grp) << GRP_LSB) | 32'(st_q.flt_part);
        end else if (bus_addr == ADDR_W'(A_VAL)) begin
            bus_rdata = {st_q.nrdy, st_q.value};
        end else if (bus_addr == ADDR_W'(A_CAPT)) begin
            bus_rdata = {st_q.capt_nrdy, st_q.capt_val};
        end
    end

    assign link_evt = st_q.link;
    assign ovf_irq  = st_q.ctl.status && st_q.ctl.irq_en;
endmodule

// File: rtl/occ_monitor_chk.sv
module occ_monitor_chk
    import occ_mon_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_CAPT-1:0] ext_capt,
    input logic [N_CAPT-1:0] link_evt,
    input logic              ovf_irq,
    input logic              st_en,
    input logic              st_status,
    input logic              st_frozen,
    input logic [VAL_W-1:0]  st_value,
    input logic              st_nrdy
);
    logic wr_ctl, wr_val, trig, quiet;

    assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(A_CTL));
    assign wr_val = bus_wr && (bus_addr == ADDR_W'(A_VAL));
    assign trig   = bus_wr && (bus_addr == ADDR_W'(A_TRIG));
    assign quiet  = !wr_val && !trig && (ext_capt == '0);

    p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_en && quiet) |=> $stable(st_value));

    p_nrdy_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val |=> st_nrdy);

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_status && !wr_ctl && !wr_val) |=> st_status);

    p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_frozen && quiet) |=> $stable(st_value));

    p_write_unfreezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val |=> !st_frozen);

    p_link_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_evt));

    p_link_has_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_evt != '0) |-> st_status);

    p_irq_has_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> st_status);
endmodule

bind occupancy_monitor occ_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ext_capt  (ext_capt),
    .link_evt  (link_evt),
    .ovf_irq   (ovf_irq),
    .st_en     (st_q.ctl.en),
    .st_status (st_q.ctl.status),
    .st_frozen (st_q.frozen),
    .st_value  (st_q.value),
    .st_nrdy   (st_q.nrdy)
);

// File: tb/tb_occupancy_monitor.sv
module tb_occupancy_monitor;
    localparam int ADDR_W = 3;
    localparam int PART_W = 16;
    localparam int GRP_W  = 8;
    localparam int LINE_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              ev_valid = 1'b0;
    logic              ev_alloc = 1'b0;
    logic [PART_W-1:0] ev_part = '0;
    logic [GRP_W-1:0]  ev_grp = '0;
    logic [LINE_W-1:0] ev_lines = '0;
    logic [5:0]        ext_capt = '0;
    logic [5:0]        link_evt;
    logic              ovf_irq;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #10 clk = ~clk;

    occupancy_monitor #(.ADDR_W(ADDR_W), .PART_W(PART_W), .GRP_W(GRP_W), .LINE_W(LINE_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_valid(ev_valid),
        .ev_alloc(ev_alloc), .ev_part(ev_part), .ev_grp(ev_grp),
        .ev_lines(ev_lines), .ext_capt(ext_capt), .link_evt(link_evt),
        .ovf_irq(ovf_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, int addr, logic [31:0] exp);
        bus_addr = ADDR_W'(addr);
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic ev(bit alloc, int part, int grp, int lines);
        @(negedge clk);
        ev_valid = 1'b1; ev_alloc = alloc;
        ev_part = PART_W'(part); ev_grp = GRP_W'(grp); ev_lines = LINE_W'(lines);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic pulse(logic [5:0] bits);
        @(negedge clk);
        ext_capt = bits;
        @(negedge clk);
        ext_capt = '0;
    endtask

    task automatic t_reset();
        rd_check("R1 reset ctrl", 0, 32'h0000_0043);
        rd_check("R1 reset value", 2, 32'h0);
        rd_check("R1 reset capture", 3, 32'h0);
        check("R12 reset irq", 32'(ovf_irq), 32'h0);
        check("R10 reset link", 32'(link_evt), 32'h0);
    endtask

    task automatic t_ctrl_bits();
        wr(0, 32'hFFFF_FFFF);
        rd_check("R1 fixed and reserved bits", 0, 32'hFF87_0743);
        check("R12 irq with status and enable", 32'(ovf_irq), 32'h1);
        wr(0, 32'h0);
        rd_check("R1 ctrl cleared", 0, 32'h0000_0043);
        check("R12 irq off", 32'(ovf_irq), 32'h0);
        rd_check("R1 trigger reads zero", 4, 32'h0);
    endtask

    task automatic t_disabled();
        ev(1, 0, 0, 5);
        rd_check("R2 disabled ignores alloc", 2, 32'h0);
    endtask

    task automatic t_count();
        wr(0, 32'h8000_0000);
        ev(1, 0, 0, 10);
        ev(1, 0, 0, 3);
        rd_check("R3 alloc sum", 2, 32'd13);
        ev(0, 0, 0, 20);
        rd_check("R3 evict floors at zero", 2, 32'd0);
        wr(2, 32'd100);
        rd_check("R3 write sets not-ready", 2, 32'h8000_0064);
        ev(1, 0, 0, 1);
        rd_check("R3 event clears not-ready", 2, 32'h0000_0065);
        ev(0, 0, 0, 5);
        rd_check("R3 evict subtracts", 2, 32'h0000_0060);
    endtask

    task automatic t_filter();
        wr(1, 32'h0002_0005);
        rd_check("R4 filter readback", 1, 32'h0002_0005);
        wr(0, 32'h8001_0000);
        wr(2, 32'd0);
        ev(1, 6, 2, 4);
        rd_check("R4 partition mismatch dropped", 2, 32'h8000_0000);
        ev(1, 5, 9, 4);
        rd_check("R4 partition match any group", 2, 32'd4);
        wr(0, 32'h8003_0000);
        ev(1, 5, 9, 4);
        rd_check("R4 group mismatch dropped", 2, 32'd4);
        ev(1, 5, 2, 1);
        rd_check("R4 both match", 2, 32'd5);
        wr(0, 32'h8002_0000);
        ev(1, 7, 2, 1);
        rd_check("R4 group only match", 2, 32'd6);
    endtask

    task automatic t_capt_ext();
        wr(0, 32'hA800_0000);
        wr(2, 32'd40);
        ev(1, 0, 0, 2);
        pulse(6'b000001);
        rd_check("R5 unselected input ignored", 3, 32'h0);
        rd_check("R5 value kept", 2, 32'd42);
        pulse(6'b000010);
        rd_check("R6 capture copies value", 3, 32'd42);
        rd_check("R6 reset after capture", 2, 32'd0);
    endtask

    task automatic t_capt_sw();
        wr(0, 32'hF000_0000);
        wr(2, 32'd77);
        wr(4, 32'h0);
        rd_check("R6 capture keeps not-ready", 3, 32'h8000_004D);
        rd_check("R6 no reset when bit clear", 2, 32'h8000_004D);
        wr(0, 32'h8000_0000);
        wr(2, 32'd5);
        wr(4, 32'h0);
        rd_check("R5 code 0 no capture", 3, 32'h8000_004D);
    endtask

    task automatic t_wrap_link();
        wr(0, 32'h8200_0300);
        wr(2, 32'h7FFF_FFFE);
        ev(1, 0, 0, 5);
        check("R10 link pulse on line 3", 32'(link_evt), 32'h4);
        rd_check("R7 value wraps", 2, 32'd3);
        rd_check("R7 status set", 0, 32'h8600_0343);
        check("R12 irq raised", 32'(ovf_irq), 32'h1);
        @(negedge clk);
        check("R10 link pulse one cycle", 32'(link_evt), 32'h0);
        check("R7 status sticky", 32'(ovf_irq), 32'h1);
        wr(0, 32'h8200_0300);
        rd_check("R7 status written to zero", 0, 32'h8200_0343);
        check("R12 irq dropped", 32'(ovf_irq), 32'h0);
    endtask

    task automatic t_freeze();
        wr(0, 32'h8100_0000);
        wr(2, 32'h7FFF_FFF0);
        ev(1, 0, 0, 32);
        rd_check("R8 frozen value held", 2, 32'h7FFF_FFF0);
        rd_check("R7 status on frozen overflow", 0, 32'h8500_0043);
        ev(1, 0, 0, 1);
        rd_check("R8 later events ignored", 2, 32'h7FFF_FFF0);
        wr(2, 32'd7);
        rd_check("R7 value write clears status", 0, 32'h8100_0043);
        rd_check("R8 write unfreezes", 2, 32'h8000_0007);
        ev(1, 0, 0, 1);
        rd_check("R8 counting resumes", 2, 32'd8);
    endtask

    task automatic t_capt_ovf();
        wr(0, 32'h8880_0000);
        wr(2, 32'h7FFF_FFFF);
        ev(1, 0, 0, 4);
        rd_check("R9 capture on overflow", 3, 32'd3);
        rd_check("R9 reset after overflow capture", 2, 32'd0);
    endtask

    task automatic t_cap_as_ovf();
        wr(0, 32'h9084_0000);
        wr(2, 32'd50);
        pulse(6'b000001);
        rd_check("R11 capture via overflow path", 3, 32'h8000_0032);
        rd_check("R11 status set", 0, 32'h9484_0043);
        rd_check("R11 value kept", 2, 32'h8000_0032);
        wr(0, 32'h9004_0000);
        wr(2, 32'd9);
        pulse(6'b000001);
        rd_check("R11 no plain capture", 3, 32'h8000_0032);
        rd_check("R11 status set again", 0, 32'h9404_0043);
    endtask

    task automatic t_link_reserved();
        wr(0, 32'h8000_0700);
        wr(2, 32'h7FFF_FFFF);
        ev(1, 0, 0, 1);
        check("R10 code 7 drives nothing", 32'(link_evt), 32'h0);
        rd_check("R7 status from overflow", 0, 32'h8400_0743);
        check("R12 irq off without enable", 32'(ovf_irq), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_bits();
        t_disabled();
        t_count();
        t_filter();
        t_capt_ext();
        t_capt_sw();
        t_wrap_link();
        t_freeze();
        t_capt_ovf();
        t_cap_as_ovf();
        t_link_reserved();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule